// File: doc/BRIEF.md
# Receive Character Queue with Error Tagging

This block is the holding buffer between a serial receiver and a host. The receiver delivers a finished character with a one-cycle strobe and three error flags (break, framing, parity). The block stores all eleven bits in one queue entry. The host pulls characters out in arrival order through a data read. It can look at any time at an 8-bit status word, which combines the error flags with live queue flags.

Error reporting has two modes. In per-character mode, the status shows the flags of the character at the head of the queue, and those flags go away when that character is read. In block mode, the flags of every character accepted are ORed together and held until the host clears them or the receiver is reset. This lets a host check one status word after moving a whole burst.

The block also gives a ready flag, a full flag, a sticky overrun flag, and an interrupt request raised when the stored count reaches a programmable level.

Top module: `rxq_stat_buf`

## Requirements
- R1: After a synchronous reset the queue is empty: `status` is 0x00, `rd_data` is 0x00, and `ready`, `full`, `irq` and `overrun` are all 0.
- R2: When `rx_valid` is high and the strobe is accepted, the character is stored with its three error flags. Pulsing `rd_en` while the queue is not empty removes the oldest entry, and its data shows on `rd_data` from the next cycle. Characters come out in arrival order.
- R3: The bits of `status` are: [7] break, [6] framing error, [5] parity error, [4] overrun, [3] always 0, [2] equal to `irq`, [1] equal to `full`, [0] equal to `ready`.
- R4: With `blk_mode`=0, `status[7:5]` holds the flags of the head entry, or 0 when the queue is empty. Reading the head replaces them with the flags of the next entry.
- R5: A strobe with `rx_brk`=1 stores exactly one entry with data 0x00 and the break flag set, whatever `rx_data` is.
- R6: With `blk_mode`=1, `status[7:5]` is the OR of the flags of all characters accepted since the last `err_clr` or `rx_clr`. Reads do not change it. If `err_clr` comes in the same cycle as a flagged character, the character's flags are kept.
- R7: `ready` is 1 when at least one entry is stored. `full` is 1 when all 256 entries are used.
- R8: `irq` is 1 when the stored count is at least `fill_lvl`. A level of 0 acts as 1.
- R9: A strobe that arrives while the queue is full and no entry is read that cycle is dropped, and the stored entries stay as they were. The drop sets `overrun`, which stays set until `err_clr` or `rx_clr`.
- R10: A strobe and a read in the same cycle are both carried out and the count does not change. This holds even when the queue is full, and `overrun` is not set in that case.
- R11: `rd_en` on an empty queue leaves `rd_data` and the read position unchanged. The next character written is the next one read.
- R12: `rx_clr` empties the queue and clears the accumulated flags and `overrun`. A strobe in the same cycle is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Character-complete strobe from the receiver |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Character is a break |
| rx_ferr | input | 1 | Framing error on this character |
| rx_perr | input | 1 | Parity error on this character |
| rd_en | input | 1 | Host data read (removes the head entry) |
| blk_mode | input | 1 | 0: per-character flags, 1: accumulated flags |
| err_clr | input | 1 | Clear accumulated flags and overrun |
| rx_clr | input | 1 | Receiver reset: flush the queue and clear flags |
| fill_lvl | input | 8 | Interrupt fill level |
| rd_data | output | 8 | Data of the last character read |
| status | output | 8 | Error flags and queue flags |
| ready | output | 1 | At least one character stored |
| full | output | 1 | Queue full |
| irq | output | 1 | Fill-level interrupt request |
| overrun | output | 1 | Sticky drop indicator |

## Verification
The two functions that can collide in one cycle are the receiver strobe and the host read. The hardest case is a strobe arriving while all 256 entries are full. The bench fills the queue completely and then drives a strobe alone, which must be dropped and must set `overrun`. It then drives a strobe together with a read, which must be accepted without a new overrun. A cycle-level reference queue inside the bench checks that the accepted character comes out last, after the 255 survivors, in order. It also checks that the popped head is the one that was removed. A second collision, a flag clear arriving together with a flagged character, is judged by the held flags after that cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DATA_W = 8;
    localparam int RXQ_ERR_W  = 3;

    // Error flags carried with each character
    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rxq_err_t;

    // One queue entry: flags above data
    typedef struct packed {
        rxq_err_t               err;
        logic [RXQ_DATA_W-1:0]  data;
    } rxq_ent_t;

    // Host-visible status word
    typedef struct packed {
        logic [RXQ_ERR_W-1:0] err;
        logic                 ovr;
        logic                 zero;
        logic                 lvl;
        logic                 full;
        logic                 rdy;
    } rxq_stat_t;

    // Build an entry; a break always stores a zero character
    function automatic rxq_ent_t rxq_make_ent(input logic [RXQ_DATA_W-1:0] d,
                                              input rxq_err_t e);
        rxq_ent_t r;
        r.err  = e;
        r.data = e.brk ? '0 : d;
        return r;
    endfunction

    function automatic rxq_stat_t rxq_make_stat(input logic [RXQ_ERR_W-1:0] e,
                                                input logic ovr,
                                                input logic lvl,
                                                input logic full,
                                                input logic rdy);
        rxq_stat_t s;
        s.err  = e;
        s.ovr  = ovr;
        s.zero = 1'b0;
        s.lvl  = lvl;
        s.full = full;
        s.rdy  = rdy;
        return s;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_req,
    input  rxq_ent_t          wr_ent,
    input  logic              rd_req,
    output rxq_ent_t          head,
    output logic [RXQ_DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              push_ok,
    output logic              drop
);

    rxq_ent_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] wr_nxt, rd_nxt;
    logic             pop_ok;
    logic             is_full, is_empty;

    assign is_full  = (count == CNT_W'(DEPTH));
    assign is_empty = (count == '0);

    // Read wins a slot first, so a full queue can still take a write
    assign pop_ok  = rd_req & ~is_empty & ~flush;
    assign push_ok = wr_req & ~flush & (~is_full | pop_ok);
    assign drop    = wr_req & ~flush & ~push_ok;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    assign head = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_nxt;
            if (pop_ok)  rd_ptr <= rd_nxt;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Data register holds the last character taken
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (pop_ok) begin
            rd_data <= head.data;
        end
    end

endmodule

// File: rtl/rxq_errtrk.sv
module rxq_errtrk
    import rxq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 err_clr,
    input  logic                 blk_mode,
    input  logic                 push_ok,
    input  logic                 drop,
    input  logic [RXQ_ERR_W-1:0] new_err,
    input  logic [RXQ_ERR_W-1:0] head_err,
    input  logic                 nonempty,
    output logic [RXQ_ERR_W-1:0] rep_err,
    output logic                 overrun
);

    logic [RXQ_ERR_W-1:0] acc;
    logic [RXQ_ERR_W-1:0] acc_base;

    assign acc_base = err_clr ? '0 : acc;

    // New flags are ORed in after the clear, so a same-cycle event survives
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            acc     <= '0;
            overrun <= 1'b0;
        end else begin
            acc     <= acc_base | (push_ok ? new_err : '0);
            overrun <= (overrun & ~err_clr) | drop;
        end
    end

    always_comb begin
        if (blk_mode) begin
            rep_err = acc;
        end else if (nonempty) begin
            rep_err = head_err;
        end else begin
            rep_err = '0;
        end
    end

endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
    parameter int DEPTH = 256,
    localparam int LVL_W = $clog2(DEPTH),
    localparam int CNT_W = LVL_W + 1
) (
    input  logic [CNT_W-1:0] count,
    input  logic [LVL_W-1:0] fill_lvl,
    output logic             ready,
    output logic             full,
    output logic             irq
);

    logic [LVL_W-1:0] lvl_eff;

    // A zero level would request with nothing stored; treat it as one
    assign lvl_eff = (fill_lvl == '0) ? LVL_W'(1) : fill_lvl;

    assign ready = (count != '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign irq   = (count >= {1'b0, lvl_eff});

endmodule

// File: rtl/rxq_stat_buf.sv
module rxq_stat_buf
    import rxq_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int LVL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_brk,
    input  logic             rx_ferr,
    input  logic             rx_perr,
    input  logic             rd_en,
    input  logic             blk_mode,
    input  logic             err_clr,
    input  logic             rx_clr,
    input  logic [LVL_W-1:0] fill_lvl,
    output logic [7:0]       rd_data,
    output logic [7:0]       status,
    output logic             ready,
    output logic             full,
    output logic             irq,
    output logic             overrun
);

    localparam int CNT_W = LVL_W + 1;

    rxq_err_t             in_err;
    rxq_ent_t             in_ent;
    rxq_ent_t             head;
    logic [CNT_W-1:0]     count;
    logic                 push_ok;
    logic                 drop;
    logic [RXQ_ERR_W-1:0] rep_err;
    rxq_stat_t            stat;

    assign in_err = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr};
    assign in_ent = rxq_make_ent(rx_data, in_err);

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (rx_clr),
        .wr_req  (rx_valid),
        .wr_ent  (in_ent),
        .rd_req  (rd_en),
        .head    (head),
        .rd_data (rd_data),
        .count   (count),
        .push_ok (push_ok),
        .drop    (drop)
    );

    rxq_errtrk u_err (
        .clk      (clk),
        .rst      (rst),
        .flush    (rx_clr),
        .err_clr  (err_clr),
        .blk_mode (blk_mode),
        .push_ok  (push_ok),
        .drop     (drop),
        .new_err  (in_err),
        .head_err (head.err),
        .nonempty (ready),
        .rep_err  (rep_err),
        .overrun  (overrun)
    );

    rxq_level #(.DEPTH(DEPTH)) u_lvl (
        .count    (count),
        .fill_lvl (fill_lvl),
        .ready    (ready),
        .full     (full),
        .irq      (irq)
    );

    assign stat   = rxq_make_stat(rep_err, overrun, irq, full, ready);
    assign status = stat;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rd_en,
    input logic             blk_mode,
    input logic             err_clr,
    input logic             rx_clr,
    input logic [LVL_W-1:0] fill_lvl,
    input logic [7:0]       rd_data,
    input logic [7:0]       status,
    input logic             ready,
    input logic             full,
    input logic             irq,
    input logic             overrun
);

    // R7
    full_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> ready);

    // R8
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ready);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun && !err_clr && !rx_clr |=> overrun);

    // R9
    drop_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        full && rx_valid && !rd_en && !rx_clr |=> overrun && full);

    // R10
    swap_at_full_chk: assert property (@(posedge clk) disable iff (rst)
        full && rx_valid && rd_en && !rx_clr && !overrun && !err_clr |=> full && !overrun);

    // R11
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        !ready && rd_en |=> $stable(rd_data));

    // R12
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rx_clr |=> !ready && !overrun && status[7:5] == 3'b000);

    // R6
    blk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        blk_mode && status[6] && !err_clr && !rx_clr |=> !blk_mode || status[6]);

    // R4
    char_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !blk_mode && !ready |-> status[7:5] == 3'b000);

endmodule

bind rxq_stat_buf rxq_chk #(.LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rd_en    (rd_en),
    .blk_mode (blk_mode),
    .err_clr  (err_clr),
    .rx_clr   (rx_clr),
    .fill_lvl (fill_lvl),
    .rd_data  (rd_data),
    .status   (status),
    .ready    (ready),
    .full     (full),
    .irq      (irq),
    .overrun  (overrun)
);

// File: tb/rxq_stat_buf_tb.sv
module rxq_stat_buf_tb;

    logic       clk;
    logic       rst;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_brk, rx_ferr, rx_perr;
    logic       rd_en, blk_mode, err_clr, rx_clr;
    logic [7:0] fill_lvl;
    logic [7:0] rd_data, status;
    logic       ready, full, irq, overrun;

    int n_chk = 0;
    int n_err = 0;

    // Reference queue and flag model
    logic [10:0] mq[$];
    logic [2:0]  m_acc;
    logic        m_ovr;

    rxq_stat_buf u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_brk(rx_brk), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
        .rd_en(rd_en), .blk_mode(blk_mode), .err_clr(err_clr), .rx_clr(rx_clr),
        .fill_lvl(fill_lvl), .rd_data(rd_data), .status(status),
        .ready(ready), .full(full), .irq(irq), .overrun(overrun)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [2:0] e;
        logic [7:0] lv;
        int         sz;
        sz = mq.size();
        if (blk_mode) e = m_acc;
        else if (sz > 0) e = mq[0][10:8];
        else e = 3'b000;
        lv = (fill_lvl == 8'd0) ? 8'd1 : fill_lvl;
        return {e, m_ovr, 1'b0, (sz >= int'(lv)), (sz == 256), (sz != 0)};
    endfunction

    // Monitor / scoreboard: updates the model at each edge and judges the read data
    always @(posedge clk) begin
        logic        do_pop, do_push;
        logic [10:0] exp_e;
        logic [10:0] new_e;
        if (rst) begin
            mq.delete();
            m_acc = 3'b000;
            m_ovr = 1'b0;
        end else if (rx_clr) begin
            mq.delete();
            m_acc = 3'b000;
            m_ovr = 1'b0;
        end else begin
            do_pop  = rd_en && (mq.size() > 0);
            do_push = rx_valid && ((mq.size() < 256) || do_pop);
            new_e   = {rx_brk, rx_ferr, rx_perr, (rx_brk ? 8'h00 : rx_data)};
            exp_e   = 11'h0;
            if (do_pop) exp_e = mq.pop_front();
            if (do_push) mq.push_back(new_e);
            if (err_clr) begin
                m_acc = 3'b000;
                m_ovr = 1'b0;
            end
            if (do_push) m_acc = m_acc | new_e[10:8];
            if (rx_valid && !do_push) m_ovr = 1'b1;
            if (do_pop) begin
                #2;
                chk("R2 read order", {24'h0, rd_data}, {24'h0, exp_e[7:0]});
            end
        end
    end

    task automatic step(input logic v, input logic [7:0] d, input logic b, input logic f,
                        input logic p, input logic rd, input logic ec, input logic rc);
        rx_valid = v; rx_data = d; rx_brk = b; rx_ferr = f; rx_perr = p;
        rd_en = rd; err_clr = ec; rx_clr = rc;
        @(negedge clk);
        rx_valid = 0; rx_data = 0; rx_brk = 0; rx_ferr = 0; rx_perr = 0;
        rd_en = 0; err_clr = 0; rx_clr = 0;
        chk("R3 status word", {24'h0, status}, {24'h0, exp_status()});
    endtask

    task automatic push(input logic [7:0] d, input logic b, input logic f, input logic p);
        step(1'b1, d, b, f, p, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pop();
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] held;
        rst = 1'b1; blk_mode = 1'b0; fill_lvl = 8'd1;
        rx_valid = 0; rx_data = 0; rx_brk = 0; rx_ferr = 0; rx_perr = 0;
        rd_en = 0; err_clr = 0; rx_clr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", {24'h0, status}, 32'h0);
        chk("R1 rd_data", {24'h0, rd_data}, 32'h0);
        chk("R1 flags", {28'h0, ready, full, irq, overrun}, 32'h0);

        // R4 / R5 per-character flags and break
        push(8'h11, 0, 0, 0);
        push(8'h22, 0, 1, 0);
        push(8'h5A, 1, 0, 0);
        push(8'h33, 0, 0, 1);
        chk("R4 head clean", {29'h0, status[7:5]}, 32'h0);
        pop();
        chk("R4 head framing", {29'h0, status[7:5]}, 32'h2);
        pop();
        chk("R5 break flag at head", {29'h0, status[7:5]}, 32'h4);
        pop();
        chk("R5 break data zero", {24'h0, rd_data}, 32'h0);
        chk("R4 head parity", {29'h0, status[7:5]}, 32'h1);
        pop();
        chk("R4 empty flags", {29'h0, status[7:5]}, 32'h0);

        // R11 read of an empty queue
        held = rd_data;
        pop();
        chk("R11 data held", {24'h0, rd_data}, {24'h0, held});
        push(8'h44, 0, 0, 0);
        pop();
        chk("R11 next read", {24'h0, rd_data}, 32'h44);

        // R8 fill level
        fill_lvl = 8'd3;
        push(8'h01, 0, 0, 0);
        push(8'h02, 0, 0, 0);
        chk("R8 below level", {31'h0, irq}, 32'h0);
        push(8'h03, 0, 0, 0);
        chk("R8 at level", {31'h0, irq}, 32'h1);
        fill_lvl = 8'd0;
        pop(); pop();
        chk("R8 level zero as one", {31'h0, irq}, 32'h1);
        pop();
        chk("R8 empty no request", {31'h0, irq}, 32'h0);

        // R6 block mode accumulation
        blk_mode = 1'b1;
        step(1'b0, 8'h00, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        push(8'h0A, 0, 1, 0);
        push(8'h0B, 0, 0, 1);
        pop(); pop();
        chk("R6 held after reads", {29'h0, status[7:5]}, 32'h3);
        step(1'b1, 8'h0C, 0, 0, 1, 1'b0, 1'b1, 1'b0);
        chk("R6 same-cycle flag kept", {29'h0, status[7:5]}, 32'h1);
        step(1'b0, 8'h00, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        chk("R6 cleared", {29'h0, status[7:5]}, 32'h0);
        pop();
        blk_mode = 1'b0;

        // R7 / R9 / R10 fill, overflow, swap at full
        for (int i = 0; i < 256; i++) push(i[7:0], 0, 0, (i % 5) == 0);
        chk("R7 full", {30'h0, full, ready}, 32'h3);
        push(8'hEE, 1, 0, 0);
        chk("R9 overrun set", {30'h0, overrun, full}, 32'h3);
        step(1'b0, 8'h00, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        chk("R9 overrun sticky", {31'h0, overrun}, 32'h1);
        step(1'b0, 8'h00, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        chk("R9 overrun cleared", {31'h0, overrun}, 32'h0);
        step(1'b1, 8'hAB, 0, 0, 0, 1'b1, 1'b0, 1'b0);
        chk("R10 swap keeps full", {30'h0, full, overrun}, 32'h2);
        for (int i = 0; i < 256; i++) pop();
        chk("R10 swapped char last", {24'h0, rd_data}, 32'hAB);
        chk("R7 drained", {30'h0, ready, full}, 32'h0);

        // R12 flush
        push(8'h61, 0, 1, 0);
        push(8'h62, 1, 0, 0);
        blk_mode = 1'b1;
        step(1'b1, 8'h77, 1, 0, 0, 1'b0, 1'b0, 1'b1);
        chk("R12 flushed", {23'h0, ready, status}, 32'h0);
        blk_mode = 1'b0;
        push(8'h55, 0, 0, 0);
        pop();
        chk("R12 fresh after flush", {24'h0, rd_data}, 32'h55);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule